// File: doc/BRIEF.md
# Receiver Multi-Frame Phase Adjuster

This block is the converter-side control logic of a serial data link in which the far end, the transmitter, owns the master multi-frame timing. The block keeps a local multi-frame counter that runs on the device clock. It drives an active-low synchronization request (`sync_n`). It also moves its own multi-frame boundary when the transmitter asks for a move.

Each cycle of the handshake starts with `sync_n` held low. While it is low, the transmitter performs code-group synchronization. The block releases `sync_n` on one of its own multi-frame boundaries, so the transmitter can see where the local boundary sits. The transmitter replies with phase-adjust fields in the configuration frame of its alignment sequence. These fields are an enable bit, a step count and a direction.

The block applies a requested move of whole device-clock steps at once. It then drops `sync_n` again to ask for a new round. The loop ends when a reply carries a zero step count or a cleared enable. At that point `aligned` is raised and the block holds its phase.

The multi-frame length is `FRAMES_PER_MF * OCTETS_PER_FRAME` device clocks. With the defaults this is 8 clocks. Decoding of the configuration fields, the lanes and the data path sit outside the block.

Top module: `mfclk_phase_adjuster`

## Requirements
- R1: While `rst` is high, `sync_n`, `aligned` and `mf_edge` are all low. In the first clock after `rst` falls, `mf_edge` pulses.
- R2: When no adjustment is applied, `mf_edge` is a single-cycle pulse that repeats every MF_LEN clocks. MF_LEN is `FRAMES_PER_MF*OCTETS_PER_FRAME`.
- R3: A low `sync_n` stays low until all three of these hold: `cgs_done` is high, `sync_n` has been low for at least MF_LEN clocks, and a multi-frame boundary arrives. `sync_n` rises in the same cycle that `mf_edge` is high.
- R4: A `cfg_valid` strobe has no effect on phase, `sync_n` or `aligned` in two cases: when `sync_n` is low, or when `aligned` is already high.
- R5: A `cfg_valid` strobe may arrive while `sync_n` is high and `aligned` is low, with `cfg_phadj`=1 and a nonzero `cfg_adjcnt`. In that case `sync_n` is low in the next cycle, and the boundary grid has already moved by that cycle. If `cfg_adjdir`=0 (advance), boundaries come `cfg_adjcnt` clocks earlier. If `cfg_adjdir`=1 (delay), they come `cfg_adjcnt` clocks later.
- R6: A step count of MF_LEN or more moves the boundary by `cfg_adjcnt` modulo MF_LEN. It still starts a new request.
- R7: A valid strobe with `cfg_phadj`=1 and `cfg_adjcnt`=0 sets `aligned` in the next cycle. `sync_n` stays high and the phase is not moved.
- R8: A valid strobe with `cfg_phadj`=0 sets `aligned` in the next cycle. The step count and direction are ignored and the phase is not moved.
- R9: Once `aligned` is high, both `aligned` and `sync_n` stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| cgs_done | input | 1 | Code-group synchronization achieved on the link |
| cfg_valid | input | 1 | One-cycle strobe: the configuration fields below are valid |
| cfg_phadj | input | 1 | Phase adjustment requested |
| cfg_adjdir | input | 1 | Direction of the move: 0 advance, 1 delay |
| cfg_adjcnt | input | ADJ_W | Number of device-clock steps to move |
| sync_n | output | 1 | Active-low synchronization request to the transmitter |
| mf_edge | output | 1 | One-cycle pulse at each local multi-frame boundary |
| aligned | output | 1 | The phase loop has finished |

## Verification
The bench measures the boundary grid after each move against the last boundary seen before the move. A design that swaps advance and delay, or that drops a step, lands on the wrong residue. A count larger than the multi-frame length checks the modulo reduction; a design without that reduction moves the boundary by the wrong amount. Strobes that arrive while the request is low, or after alignment, must leave the grid untouched; a design that takes them would show a shifted boundary. Holding `cgs_done` low tests that the request is not released early, and that it is released only on a boundary after the minimum hold.

// File: rtl/mfa_pkg.sv
package mfa_pkg;

  typedef enum logic [1:0] {
    ST_REQUEST = 2'd0,
    ST_AWAIT   = 2'd1,
    ST_LOCKED  = 2'd2
  } mfa_state_e;

endpackage

// File: rtl/mfa_step_decode.sv
module mfa_step_decode #(
  parameter int MF_LEN = 8,
  parameter int ADJ_W  = 4,
  parameter int CNT_W  = 3
) (
  input  logic             phadj,
  input  logic             adjdir,
  input  logic [ADJ_W-1:0] adjcnt,
  output logic             want_move,
  output logic [CNT_W-1:0] fwd_step
);
  localparam int SW = (ADJ_W > CNT_W) ? ADJ_W + 1 : CNT_W + 1;

  logic [SW-1:0]    wide_cnt;
  logic [CNT_W-1:0] red_cnt;

  // reduce the requested count modulo the multi-frame length
  always_comb begin
    wide_cnt = SW'(adjcnt) % SW'(MF_LEN);
    red_cnt  = CNT_W'(wide_cnt);
  end

  // express the move as an extra forward increment of the counter
  always_comb begin
    if (red_cnt == '0)
      fwd_step = '0;
    else if (adjdir)
      fwd_step = CNT_W'((CNT_W+1)'(MF_LEN) - (CNT_W+1)'(red_cnt));
    else
      fwd_step = red_cnt;
  end

  assign want_move = phadj && (adjcnt != '0);

endmodule

// File: rtl/mfa_lmfc_counter.sv
module mfa_lmfc_counter #(
  parameter int MF_LEN = 8,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             jump_en,
  input  logic [CNT_W-1:0] jump_fwd,
  output logic             boundary_next,
  output logic             edge_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum = {1'b0, cnt_q} + (CNT_W+1)'(1);
    if (jump_en)
      sum = sum + {1'b0, jump_fwd};
    if (sum >= (CNT_W+1)'(MF_LEN))
      cnt_d = CNT_W'(sum - (CNT_W+1)'(MF_LEN));
    else
      cnt_d = CNT_W'(sum);
  end

  assign boundary_next = (cnt_d == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_W'(MF_LEN - 1);
      edge_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      edge_o <= boundary_next;
    end
  end

endmodule

// File: rtl/mfa_sync_ctrl.sv
module mfa_sync_ctrl
  import mfa_pkg::*;
#(
  parameter int MF_LEN = 8,
  parameter int HOLD_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cgs_done,
  input  logic cfg_valid,
  input  logic want_move,
  input  logic boundary_next,
  output logic apply,
  output logic sync_n,
  output logic aligned
);
  mfa_state_e  state_q, state_d;
  logic [HOLD_W-1:0] hold_q;
  logic hold_met;
  logic release_req;

  assign hold_met    = (hold_q >= HOLD_W'(MF_LEN - 1));
  assign release_req = hold_met && cgs_done && boundary_next;
  assign apply       = (state_q == ST_AWAIT) && cfg_valid && want_move;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_REQUEST: if (release_req) state_d = ST_AWAIT;
      ST_AWAIT: begin
        if (cfg_valid)
          state_d = want_move ? ST_REQUEST : ST_LOCKED;
      end
      ST_LOCKED:  state_d = ST_LOCKED;
      default:    state_d = ST_REQUEST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_REQUEST;
      hold_q  <= '0;
      sync_n  <= 1'b0;
      aligned <= 1'b0;
    end else begin
      state_q <= state_d;
      sync_n  <= (state_d != ST_REQUEST);
      aligned <= (state_d == ST_LOCKED);
      if (state_d != ST_REQUEST || state_q != ST_REQUEST)
        hold_q <= '0;
      else if (!hold_met)
        hold_q <= hold_q + HOLD_W'(1);
    end
  end

endmodule

// File: rtl/mfclk_phase_adjuster.sv
module mfclk_phase_adjuster #(
  parameter int FRAMES_PER_MF    = 4,
  parameter int OCTETS_PER_FRAME = 2,
  parameter int ADJ_W            = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cgs_done,
  input  logic             cfg_valid,
  input  logic             cfg_phadj,
  input  logic             cfg_adjdir,
  input  logic [ADJ_W-1:0] cfg_adjcnt,
  output logic             sync_n,
  output logic             mf_edge,
  output logic             aligned
);
  localparam int MF_LEN = FRAMES_PER_MF * OCTETS_PER_FRAME;
  localparam int CNT_W  = (MF_LEN > 2) ? $clog2(MF_LEN) : 1;
  localparam int HOLD_W = CNT_W + 1;

  logic             want_move;
  logic [CNT_W-1:0] fwd_step;
  logic             apply;
  logic             boundary_next;

  mfa_step_decode #(.MF_LEN(MF_LEN), .ADJ_W(ADJ_W), .CNT_W(CNT_W)) u_dec (
    .phadj     (cfg_phadj),
    .adjdir    (cfg_adjdir),
    .adjcnt    (cfg_adjcnt),
    .want_move (want_move),
    .fwd_step  (fwd_step)
  );

  mfa_lmfc_counter #(.MF_LEN(MF_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk           (clk),
    .rst           (rst),
    .jump_en       (apply),
    .jump_fwd      (fwd_step),
    .boundary_next (boundary_next),
    .edge_o        (mf_edge)
  );

  mfa_sync_ctrl #(.MF_LEN(MF_LEN), .HOLD_W(HOLD_W)) u_ctl (
    .clk           (clk),
    .rst           (rst),
    .cgs_done      (cgs_done),
    .cfg_valid     (cfg_valid),
    .want_move     (want_move),
    .boundary_next (boundary_next),
    .apply         (apply),
    .sync_n        (sync_n),
    .aligned       (aligned)
  );

endmodule

// File: rtl/mfa_checker.sv
module mfa_checker #(
  parameter int MF_LEN = 8,
  parameter int ADJ_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cgs_done,
  input logic             cfg_valid,
  input logic             cfg_phadj,
  input logic [ADJ_W-1:0] cfg_adjcnt,
  input logic             sync_n,
  input logic             mf_edge,
  input logic             aligned
);
  int low_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      low_cnt <= 0;
    else if (!sync_n)
      low_cnt <= (low_cnt < MF_LEN) ? low_cnt + 1 : low_cnt;
    else
      low_cnt <= 0;
  end

  AST_RELEASE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> mf_edge); // R3
  AST_RELEASE_NEEDS_CGS: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> $past(cgs_done)); // R3
  AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_n) |-> (low_cnt >= MF_LEN - 1)); // R3
  AST_MOVE_DROPS_SYNC: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && sync_n && !aligned && cfg_phadj && cfg_adjcnt != '0) |=> !sync_n); // R5
  AST_LOCK_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> ($past(cfg_valid) && $past(sync_n))); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    aligned |=> aligned); // R9
  AST_LOCK_SYNC_HIGH: assert property (@(posedge clk) disable iff (rst)
    aligned |-> sync_n); // R9

endmodule

bind mfclk_phase_adjuster mfa_checker #(.MF_LEN(MF_LEN), .ADJ_W(ADJ_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cgs_done   (cgs_done),
  .cfg_valid  (cfg_valid),
  .cfg_phadj  (cfg_phadj),
  .cfg_adjcnt (cfg_adjcnt),
  .sync_n     (sync_n),
  .mf_edge    (mf_edge),
  .aligned    (aligned)
);

// File: tb/mfclk_phase_adjuster_bench.sv
module mfclk_phase_adjuster_bench;
  localparam int L = 8;
  localparam int NV = 5;
  // {phadj, dir, adjcnt[3:0], expected forward offset[3:0], expect aligned}
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd3,  4'd3, 1'b0},   // R5 advance 3
    {1'b1, 1'b1, 4'd2,  4'd6, 1'b0},   // R5 delay 2
    {1'b1, 1'b0, 4'd10, 4'd2, 1'b0},   // R6 advance 10 -> 2
    {1'b1, 1'b1, 4'd1,  4'd7, 1'b0},   // R5 delay 1
    {1'b1, 1'b0, 4'd0,  4'd0, 1'b1}    // R7 zero count
  };

  logic clk = 1'b0;
  logic rst, cgs_done, cfg_valid, cfg_phadj, cfg_adjdir;
  logic [3:0] cfg_adjcnt;
  logic sync_n, mf_edge, aligned;
  int cyc = 0, last_edge = 0, checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mfclk_phase_adjuster u_mfclk_phase_adjuster (
    .clk(clk), .rst(rst), .cgs_done(cgs_done), .cfg_valid(cfg_valid),
    .cfg_phadj(cfg_phadj), .cfg_adjdir(cfg_adjdir), .cfg_adjcnt(cfg_adjcnt),
    .sync_n(sync_n), .mf_edge(mf_edge), .aligned(aligned)
  );

  function automatic int md(input int x);
    return ((x % L) + L) % L;
  endfunction

  task automatic tick();
    @(posedge clk);
    #5;
    cyc++;
    if (mf_edge === 1'b1) last_edge = cyc;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_cfg(input logic ph, input logic dir, input logic [3:0] n);
    cfg_phadj = ph; cfg_adjdir = dir; cfg_adjcnt = n; cfg_valid = 1'b1;
    tick();
    cfg_valid = 1'b0;
  endtask

  // every boundary over two multi-frames must keep the residue of t0 shifted by off
  task automatic grid_check(input int t0, input int off, input string req);
    for (int i = 0; i < 2 * L; i++) begin
      tick();
      if (mf_edge === 1'b1) chk(md(cyc - t0 + off) == 0, req, md(cyc - t0 + off), 0);
    end
  endtask

  task automatic wait_release();
    while (sync_n !== 1'b1) tick();
  endtask

  initial begin
    int t0, ta, n;
    rst = 1'b1; cgs_done = 1'b1; cfg_valid = 1'b0;
    cfg_phadj = 1'b0; cfg_adjdir = 1'b0; cfg_adjcnt = '0;
    tick(); tick(); tick();
    chk(sync_n == 0 && aligned == 0 && mf_edge == 0, "R1 reset outputs",
        {sync_n, aligned, mf_edge}, 0);
    rst = 1'b0;
    tick();
    chk(mf_edge == 1, "R1 first boundary", mf_edge, 1);
    wait_release();
    chk(mf_edge == 1, "R3 release on boundary", mf_edge, 1);

    for (int v = 0; v < NV; v++) begin
      wait_release();
      tick(); tick();
      t0 = last_edge;
      pulse_cfg(VEC[v][10], VEC[v][9], VEC[v][8:5]);
      ta = cyc;
      if (VEC[v][0]) begin
        chk(aligned == 1 && sync_n == 1, "R7 aligned on zero count", {aligned, sync_n}, 3);
        if (mf_edge === 1'b1) chk(md(cyc - t0) == 0, "R7 phase kept", md(cyc - t0), 0);
        grid_check(t0, 0, "R7 phase kept");
      end else begin
        chk(sync_n == 0 && aligned == 0, "R5 new request", {sync_n, aligned}, 0);
        n = 0;
        while (mf_edge !== 1'b1 && n < 2 * L) begin tick(); n++; end
        chk(md(cyc - t0 + int'(VEC[v][4:1])) == 0, (v == 2) ? "R6 modulo move" : "R5 move",
            md(cyc - t0 + int'(VEC[v][4:1])), 0);
        wait_release();
        chk(cyc - ta >= L, "R3 minimum hold", cyc - ta, L);
        chk(mf_edge == 1, "R3 release on boundary", mf_edge, 1);
      end
    end

    // R4 and R9: strobe after alignment is ignored
    t0 = last_edge;
    pulse_cfg(1'b1, 1'b0, 4'd3);
    chk(aligned == 1 && sync_n == 1, "R9 lock holds", {aligned, sync_n}, 3);
    if (mf_edge === 1'b1) chk(md(cyc - t0) == 0, "R4 no move when aligned", md(cyc - t0), 0);
    grid_check(t0, 0, "R4 no move when aligned");
    chk(aligned == 1 && sync_n == 1, "R9 lock holds", {aligned, sync_n}, 3);

    // second reset, R2 period
    rst = 1'b1; cgs_done = 1'b0;
    tick(); tick();
    chk(sync_n == 0 && aligned == 0 && mf_edge == 0, "R1 reset clears lock",
        {sync_n, aligned, mf_edge}, 0);
    rst = 1'b0;
    tick();
    chk(mf_edge == 1, "R1 first boundary", mf_edge, 1);
    t0 = cyc; n = 0;
    for (int i = 0; i < L - 1; i++) begin tick(); if (mf_edge) n++; end
    chk(n == 0, "R2 no pulse inside multi-frame", n, 0);
    tick();
    chk(mf_edge == 1 && cyc - t0 == L, "R2 period", cyc - t0, L);

    // R4: strobe while request low; R3: cgs_done low keeps request low
    t0 = last_edge;
    pulse_cfg(1'b1, 1'b0, 4'd3);
    chk(sync_n == 0 && aligned == 0, "R4 ignored while low", {sync_n, aligned}, 0);
    grid_check(t0, 0, "R4 no move while low");
    grid_check(t0, 0, "R2 steady grid");
    chk(sync_n == 0, "R3 held without cgs", sync_n, 0);
    cgs_done = 1'b1;
    wait_release();
    chk(mf_edge == 1, "R3 release on boundary", mf_edge, 1);

    // R8: enable cleared, nonzero count ignored
    tick();
    t0 = last_edge;
    pulse_cfg(1'b0, 1'b1, 4'd5);
    chk(aligned == 1 && sync_n == 1, "R8 aligned without move", {aligned, sync_n}, 3);
    if (mf_edge === 1'b1) chk(md(cyc - t0) == 0, "R8 phase kept", md(cyc - t0), 0);
    grid_check(t0, 0, "R8 phase kept");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule